// File: doc/BRIEF.md
# External Memory Bus Port Controller

The controller sits between a processor's fetch and load/store paths and a group of general-purpose pins that can serve either as plain I/O ports or as an external memory bus. For each program fetch it decides whether the address belongs to on-chip program memory or to the external bus. The decision uses the external-access pin and a fixed address boundary. External accesses run as a short single-strobe cycle. Address and data use separate pins, so no multiplexing is involved. The program-memory strobe is kept apart from the data-memory read and write strobes.

A per-pin-group select register decides whether each group carries its bus role or its I/O latch value. Any reset cause loads this register. When the external-access pin is low, the register is filled with ones so the part can boot from external memory. When the pin is high, the register is cleared. Software may later rewrite the register, for example to give an unused upper-address group back to I/O.

Top module: `extbus_port_ctrl`

## Requirements
- R1: With `ea_n` high, a fetch below 0x20000 completes as internal: `done` pulses with `done_ext`=0 in the cycle after the request edge, and no strobe is asserted. A fetch at 0x20000 or above runs an external cycle.
- R2: With `ea_n` low, every fetch runs an external cycle, whatever its address.
- R3: Each reset cause (`rst`, `brk_rst`, `wdt_rst`, `trap_rst`) loads `port_sel` with all ones if `ea_n` is low and with all zeros if it is high.
- R4: Outside reset, a `cfg_we` pulse loads `cfg_wdata` into `port_sel`. Bits 0..2 select the three address pin groups (bit 0 carries address bits 7:0). Bit 3 selects the data pins, bit 4 the program strobe pin and bit 5 the read/write strobe pins. A 1 selects the bus role.
- R5: An external access drives its address on the pins from the cycle after the request edge until `done`, with exactly one strobe-low cycle in the middle. `done` pulses with `done_ext`=1 four cycles after the request edge.
- R6: For a fetch or a read, `rdata` holds the value `data_pin_in` had on the clock edge that ends the strobe cycle.
- R7: A fetch strobes `psen_n`, a read strobes `rd_n` and a write strobes `wr_n`. During a write, `data_pin_oe` is 1 and `data_pin_out` equals the write data.
- R8: No two of the strobes `psen_n`, `rd_n`, `wr_n` are ever low together.
- R9: If requests arrive together, a fetch wins over a read and a read wins over a write. Requests that arrive while `busy` is high are dropped.
- R10: A pin group whose select bit is 0 outputs its I/O latch value, even during an external access. For the data pins this means `io_data_latch` and `io_data_oe`.

Ports with bit widths:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high external reset |
| brk_rst | input | 1 | Reset caused by a break instruction |
| wdt_rst | input | 1 | Reset caused by watchdog overflow |
| trap_rst | input | 1 | Reset caused by an opcode trap |
| ea_n | input | 1 | External-access pin, low forces all fetches external |
| cfg_we | input | 1 | Select register write strobe |
| cfg_wdata | input | 6 | Select register write value |
| fetch_req | input | 1 | Program fetch request |
| fetch_addr | input | 20 | Program fetch address |
| rd_req | input | 1 | External data read request |
| wr_req | input | 1 | External data write request |
| dm_addr | input | 20 | Data access address |
| dm_wdata | input | 8 | Data write value |
| busy | output | 1 | External cycle in progress |
| done | output | 1 | One-cycle access completion pulse |
| done_ext | output | 1 | Completed access used the external bus |
| rdata | output | 8 | Captured read or fetch data |
| io_addr_latch | input | 24 | I/O latch values of the three address pin groups |
| io_data_latch | input | 8 | I/O latch value of the data pins |
| io_data_oe | input | 1 | I/O direction of the data pins |
| io_ctl_latch | input | 3 | I/O latch values of the program, read and write strobe pins |
| addr_pins | output | 24 | Address pin group outputs |
| data_pin_out | output | 8 | Data pin output value |
| data_pin_oe | output | 1 | Data pin output enable |
| data_pin_in | input | 8 | Data pin input value |
| psen_n | output | 1 | Program memory strobe pin, active low |
| rd_n | output | 1 | Data read strobe pin, active low |
| wr_n | output | 1 | Data write strobe pin, active low |
| port_sel | output | 6 | Per-group I/O or bus mux select |

## Verification
Two situations are hard to reach from the pins. The first is a group being in I/O mode while a bus cycle runs. The bench gets there by booting with `ea_n` low, so every group starts in bus mode. It then rewrites the select register to clear one upper-address bit and starts an external fetch. At the strobe it checks that the upper group shows its I/O latch while the lower groups carry the address. The second is capture timing. The bench changes `data_pin_in` just after the strobe cycle, so only data captured at the strobe's rising edge matches.

// File: rtl/ebpc_pkg.sv
package ebpc_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_STRB  = 2'd2,
    ST_HOLD  = 2'd3
  } bus_state_t;
endpackage

// File: rtl/ebpc_decode.sv
module ebpc_decode #(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned INT_LIMIT = 32'h20000
) (
  input  logic              ea_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              is_ext
);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(INT_LIMIT);

  always_comb begin
    is_ext = (!ea_n) || (addr >= LIMIT);
  end
endmodule

// File: rtl/ebpc_cfg.sv
module ebpc_cfg #(
  parameter int unsigned SEL_W = 6
) (
  input  logic             clk,
  input  logic             rst_any,
  input  logic             ea_n,
  input  logic             we,
  input  logic [SEL_W-1:0] wdata,
  output logic [SEL_W-1:0] sel
);
  always_ff @(posedge clk) begin
    if (rst_any) begin
      sel <= {SEL_W{~ea_n}};
    end else if (we) begin
      sel <= wdata;
    end
  end
endmodule

// File: rtl/ebpc_seq.sv
module ebpc_seq
  import ebpc_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_any,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_ext,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] dm_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] din,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              psen_a,
  output logic              rd_a,
  output logic              wr_a,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              done_ext,
  output logic              busy
);
  bus_state_t state;
  acc_kind_t  kind;

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst_any) begin
      state    <= ST_IDLE;
      kind     <= ACC_FETCH;
      bus_addr <= '0;
      psen_a   <= 1'b0;
      rd_a     <= 1'b0;
      wr_a     <= 1'b0;
      dout     <= '0;
      dout_en  <= 1'b0;
      rdata    <= '0;
      done     <= 1'b0;
      done_ext <= 1'b0;
    end else begin
      done     <= 1'b0;
      done_ext <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (fetch_req) begin
            if (fetch_ext) begin
              kind     <= ACC_FETCH;
              bus_addr <= fetch_addr;
              state    <= ST_SETUP;
            end else begin
              done <= 1'b1;
            end
          end else if (rd_req) begin
            kind     <= ACC_READ;
            bus_addr <= dm_addr;
            state    <= ST_SETUP;
          end else if (wr_req) begin
            kind     <= ACC_WRITE;
            bus_addr <= dm_addr;
            dout     <= wdata;
            dout_en  <= 1'b1;
            state    <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          psen_a <= (kind == ACC_FETCH);
          rd_a   <= (kind == ACC_READ);
          wr_a   <= (kind == ACC_WRITE);
          state  <= ST_STRB;
        end
        ST_STRB: begin
          psen_a <= 1'b0;
          rd_a   <= 1'b0;
          wr_a   <= 1'b0;
          if (kind != ACC_WRITE) begin
            rdata <= din;
          end
          state <= ST_HOLD;
        end
        ST_HOLD: begin
          dout_en  <= 1'b0;
          done     <= 1'b1;
          done_ext <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ebpc_pinmux.sv
module ebpc_pinmux #(
  parameter int unsigned NPORT  = 3,
  parameter int unsigned PORT_W = 8,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned SEL_W = NPORT + 3,
  localparam int unsigned PADW  = NPORT * PORT_W
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [PADW-1:0]   bus_addr,
  input  logic [PADW-1:0]   io_addr,
  input  logic              psen_a,
  input  logic              rd_a,
  input  logic              wr_a,
  input  logic [2:0]        io_ctl,
  input  logic [DATA_W-1:0] bus_dout,
  input  logic              bus_oe,
  input  logic [DATA_W-1:0] io_dout,
  input  logic              io_oe,
  output logic [PADW-1:0]   addr_pins,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n
);
  for (genvar g = 0; g < NPORT; g++) begin : g_port
    assign addr_pins[g*PORT_W +: PORT_W] =
      sel[g] ? bus_addr[g*PORT_W +: PORT_W] : io_addr[g*PORT_W +: PORT_W];
  end

  always_comb begin
    data_out = sel[NPORT] ? bus_dout : io_dout;
    data_oe  = sel[NPORT] ? bus_oe   : io_oe;
    psen_n   = sel[NPORT+1] ? ~psen_a : io_ctl[0];
    rd_n     = sel[NPORT+2] ? ~rd_a   : io_ctl[1];
    wr_n     = sel[NPORT+2] ? ~wr_a   : io_ctl[2];
  end
endmodule

// File: rtl/extbus_port_ctrl.sv
module extbus_port_ctrl #(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PORT_W    = 8,
  parameter int unsigned INT_LIMIT = 32'h20000,
  localparam int unsigned NPORT    = (ADDR_W + PORT_W - 1) / PORT_W,
  localparam int unsigned SEL_W    = NPORT + 3,
  localparam int unsigned PADW     = NPORT * PORT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              brk_rst,
  input  logic              wdt_rst,
  input  logic              trap_rst,
  input  logic              ea_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_wdata,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] dm_addr,
  input  logic [DATA_W-1:0] dm_wdata,
  output logic              busy,
  output logic              done,
  output logic              done_ext,
  output logic [DATA_W-1:0] rdata,
  input  logic [PADW-1:0]   io_addr_latch,
  input  logic [DATA_W-1:0] io_data_latch,
  input  logic              io_data_oe,
  input  logic [2:0]        io_ctl_latch,
  output logic [PADW-1:0]   addr_pins,
  output logic [DATA_W-1:0] data_pin_out,
  output logic              data_pin_oe,
  input  logic [DATA_W-1:0] data_pin_in,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [SEL_W-1:0]  port_sel
);
  logic              rst_any;
  logic              fetch_ext;
  logic [ADDR_W-1:0] bus_addr;
  logic [PADW-1:0]   bus_addr_pad;
  logic              psen_a, rd_a, wr_a;
  logic [DATA_W-1:0] bus_dout;
  logic              bus_oe;

  assign rst_any      = rst | brk_rst | wdt_rst | trap_rst;
  assign bus_addr_pad = PADW'(bus_addr);

  ebpc_decode #(.ADDR_W(ADDR_W), .INT_LIMIT(INT_LIMIT)) u_decode (
    .ea_n   (ea_n),
    .addr   (fetch_addr),
    .is_ext (fetch_ext)
  );

  ebpc_cfg #(.SEL_W(SEL_W)) u_cfg (
    .clk     (clk),
    .rst_any (rst_any),
    .ea_n    (ea_n),
    .we      (cfg_we),
    .wdata   (cfg_wdata),
    .sel     (port_sel)
  );

  ebpc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst_any    (rst_any),
    .fetch_req  (fetch_req),
    .fetch_addr (fetch_addr),
    .fetch_ext  (fetch_ext),
    .rd_req     (rd_req),
    .wr_req     (wr_req),
    .dm_addr    (dm_addr),
    .wdata      (dm_wdata),
    .din        (data_pin_in),
    .bus_addr   (bus_addr),
    .psen_a     (psen_a),
    .rd_a       (rd_a),
    .wr_a       (wr_a),
    .dout       (bus_dout),
    .dout_en    (bus_oe),
    .rdata      (rdata),
    .done       (done),
    .done_ext   (done_ext),
    .busy       (busy)
  );

  ebpc_pinmux #(.NPORT(NPORT), .PORT_W(PORT_W), .DATA_W(DATA_W)) u_pinmux (
    .sel       (port_sel),
    .bus_addr  (bus_addr_pad),
    .io_addr   (io_addr_latch),
    .psen_a    (psen_a),
    .rd_a      (rd_a),
    .wr_a      (wr_a),
    .io_ctl    (io_ctl_latch),
    .bus_dout  (bus_dout),
    .bus_oe    (bus_oe),
    .io_dout   (io_data_latch),
    .io_oe     (io_data_oe),
    .addr_pins (addr_pins),
    .data_out  (data_pin_out),
    .data_oe   (data_pin_oe),
    .psen_n    (psen_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n)
  );
endmodule

// File: rtl/ebpc_chk.sv
module ebpc_chk #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned SEL_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              brk_rst,
  input logic              wdt_rst,
  input logic              trap_rst,
  input logic              ea_n,
  input logic [SEL_W-1:0]  sel,
  input logic              psen_a,
  input logic              rd_a,
  input logic              wr_a,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              busy,
  input logic              done,
  input logic              done_ext,
  input logic              dout_en
);
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (rst)
    $countones({psen_a, rd_a, wr_a}) <= 1);

  p_strobe_single_r5: assert property (@(posedge clk) disable iff (rst)
    (psen_a | rd_a | wr_a) |=> !(psen_a | rd_a | wr_a));

  p_addr_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(bus_addr));

  p_int_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (done && !done_ext) |-> !(psen_a | rd_a | wr_a));

  p_preset_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(brk_rst | wdt_rst | trap_rst) && !$past(ea_n)) |-> (&sel));

  p_write_drive_r7: assert property (@(posedge clk) disable iff (rst)
    wr_a |-> dout_en);
endmodule

bind extbus_port_ctrl ebpc_chk #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .brk_rst  (brk_rst),
  .wdt_rst  (wdt_rst),
  .trap_rst (trap_rst),
  .ea_n     (ea_n),
  .sel      (port_sel),
  .psen_a   (psen_a),
  .rd_a     (rd_a),
  .wr_a     (wr_a),
  .bus_addr (bus_addr),
  .busy     (busy),
  .done     (done),
  .done_ext (done_ext),
  .dout_en  (bus_oe)
);

// File: tb/extbus_port_ctrl_tb.sv
module extbus_port_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1, brk_rst = 1'b0, wdt_rst = 1'b0, trap_rst = 1'b0;
  logic        ea_n = 1'b1;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_wdata = '0;
  logic        fetch_req = 1'b0, rd_req = 1'b0, wr_req = 1'b0;
  logic [19:0] fetch_addr = '0, dm_addr = '0;
  logic [7:0]  dm_wdata = '0;
  logic        busy, done, done_ext;
  logic [7:0]  rdata;
  logic [23:0] io_addr_latch = 24'h9A_0000;
  logic [7:0]  io_data_latch = 8'h66;
  logic        io_data_oe = 1'b1;
  logic [2:0]  io_ctl_latch = 3'b111;
  logic [23:0] addr_pins;
  logic [7:0]  data_pin_out;
  logic        data_pin_oe;
  logic [7:0]  data_pin_in = '0;
  logic        psen_n, rd_n, wr_n;
  logic [5:0]  port_sel;

  int checks = 0;
  int errors = 0;
  int wd = 0;

  always #2.5 clk = ~clk;

  extbus_port_ctrl u_dut (
    .clk(clk), .rst(rst), .brk_rst(brk_rst), .wdt_rst(wdt_rst), .trap_rst(trap_rst),
    .ea_n(ea_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .rd_req(rd_req), .wr_req(wr_req),
    .dm_addr(dm_addr), .dm_wdata(dm_wdata), .busy(busy), .done(done), .done_ext(done_ext),
    .rdata(rdata), .io_addr_latch(io_addr_latch), .io_data_latch(io_data_latch),
    .io_data_oe(io_data_oe), .io_ctl_latch(io_ctl_latch), .addr_pins(addr_pins),
    .data_pin_out(data_pin_out), .data_pin_oe(data_pin_oe), .data_pin_in(data_pin_in),
    .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .port_sel(port_sel)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-access observations
  int          n_psen, n_rd, n_wr, n_cyc;
  logic        overlap, got_done, got_ext, wr_oe_ok;
  logic [23:0] setup_addr, strobe_addr;
  logic [7:0]  strobe_dout;

  task automatic access(input logic f, input logic r, input logic w,
                        input logic [19:0] a, input logic [7:0] wd_v, input logic [7:0] d);
    logic strobe_seen;
    @(negedge clk);
    fetch_req = f; rd_req = r; wr_req = w;
    fetch_addr = a; dm_addr = a; dm_wdata = wd_v; data_pin_in = d;
    n_psen = 0; n_rd = 0; n_wr = 0; n_cyc = 0;
    overlap = 1'b0; got_done = 1'b0; got_ext = 1'b0; wr_oe_ok = 1'b1;
    setup_addr = '0; strobe_addr = '0; strobe_dout = '0; strobe_seen = 1'b0;
    for (int i = 0; i < 10 && !got_done; i++) begin
      @(negedge clk);
      fetch_req = 1'b0; rd_req = 1'b0; wr_req = 1'b0;
      if (strobe_seen) data_pin_in = ~d;
      n_cyc = i + 1;
      if (i == 0) setup_addr = addr_pins;
      if ((32'(!psen_n) + 32'(!rd_n) + 32'(!wr_n)) > 1) overlap = 1'b1;
      if (!psen_n || !rd_n || !wr_n) begin
        strobe_addr = addr_pins;
        strobe_dout = data_pin_out;
        strobe_seen = 1'b1;
      end
      if (!psen_n) n_psen++;
      if (!rd_n)   n_rd++;
      if (!wr_n) begin
        n_wr++;
        if (!data_pin_oe) wr_oe_ok = 1'b0;
      end
      if (done) begin
        got_done = 1'b1;
        got_ext  = done_ext;
      end
    end
  endtask

  typedef struct packed {
    logic        ea;
    logic [1:0]  kind;   // 0 fetch, 1 read, 2 write
    logic [19:0] addr;
    logic [7:0]  din;
    logic [7:0]  wdat;
    logic        ext;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 2'd0, 20'h00000, 8'h11, 8'h00, 1'b0},
    '{1'b1, 2'd0, 20'h1FFFF, 8'h22, 8'h00, 1'b0},
    '{1'b1, 2'd0, 20'h20000, 8'hA5, 8'h00, 1'b1},
    '{1'b1, 2'd0, 20'hFFFFF, 8'h3C, 8'h00, 1'b1},
    '{1'b0, 2'd0, 20'h00010, 8'h81, 8'h00, 1'b1},
    '{1'b0, 2'd0, 20'h1FFFF, 8'h7E, 8'h00, 1'b1},
    '{1'b1, 2'd1, 20'h12345, 8'hC3, 8'h00, 1'b1},
    '{1'b1, 2'd2, 20'hABCDE, 8'h00, 8'h5A, 1'b1}
  };

  task automatic write_cfg(input logic [5:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_cause(input int which);
    @(negedge clk);
    case (which)
      0: rst = 1'b1;
      1: brk_rst = 1'b1;
      2: wdt_rst = 1'b1;
      default: trap_rst = 1'b1;
    endcase
    @(negedge clk);
    rst = 1'b0; brk_rst = 1'b0; wdt_rst = 1'b0; trap_rst = 1'b0;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=<20000", wd);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset state with ea_n high: all groups in I/O role
    chk(port_sel == 6'h00, "R3 reset ea_n high sel", 32'(port_sel), 32'h00);
    chk(busy == 1'b0 && psen_n == io_ctl_latch[0], "R10 reset idle pins", {busy, psen_n}, {1'b0, io_ctl_latch[0]});
    chk(data_pin_out == 8'h66 && data_pin_oe, "R10 data pins io role", 32'(data_pin_out), 32'h66);

    write_cfg(6'h3F);
    chk(port_sel == 6'h3F, "R4 cfg write", 32'(port_sel), 32'h3F);

    // Table walk
    foreach (VECS[k]) begin
      vec_t v;
      v = VECS[k];
      ea_n = v.ea;
      access(v.kind == 2'd0, v.kind == 2'd1, v.kind == 2'd2, v.addr, v.wdat, v.din);
      chk(got_done && got_ext == v.ext, v.ea ? "R1 ext decision" : "R2 ea_n low all external",
          {got_done, got_ext}, {1'b1, v.ext});
      chk(n_cyc == (v.ext ? 4 : 1), "R5 completion latency", n_cyc, v.ext ? 4 : 1);
      chk(!overlap, "R8 strobe overlap", 32'(overlap), 0);
      chk(n_psen == ((v.ext && v.kind == 2'd0) ? 1 : 0) && n_rd == (v.kind == 2'd1 ? 1 : 0)
          && n_wr == (v.kind == 2'd2 ? 1 : 0), "R7 strobe selection",
          {8'(n_psen), 8'(n_rd), 8'(n_wr)}, {8'((v.ext && v.kind == 2'd0) ? 1 : 0),
          8'(v.kind == 2'd1 ? 1 : 0), 8'(v.kind == 2'd2 ? 1 : 0)});
      if (v.ext) begin
        chk(setup_addr == 24'(v.addr) && strobe_addr == 24'(v.addr), "R5 address hold",
            32'(strobe_addr), 32'(v.addr));
      end
      if (v.ext && v.kind != 2'd2) begin
        chk(rdata == v.din, "R6 capture at strobe end", 32'(rdata), 32'(v.din));
      end
      if (v.kind == 2'd2) begin
        chk(wr_oe_ok && strobe_dout == v.wdat, "R7 write data drive", 32'(strobe_dout), 32'(v.wdat));
      end
    end

    // R3: every reset cause with ea_n low presets the bus role
    ea_n = 1'b0;
    for (int c = 0; c < 4; c++) begin
      write_cfg(6'h00);
      pulse_cause(c);
      chk(port_sel == 6'h3F, "R3 preset on reset cause", 32'(port_sel), 32'h3F);
    end
    ea_n = 1'b1;
    write_cfg(6'h3F);
    pulse_cause(3);
    chk(port_sel == 6'h00, "R3 trap with ea_n high", 32'(port_sel), 32'h00);

    // R4/R10: upper address group handed back to I/O during an external fetch
    ea_n = 1'b0;
    pulse_cause(0);
    write_cfg(6'h3B);
    access(1'b1, 1'b0, 1'b0, 20'h45678, 8'h00, 8'h99);
    chk(strobe_addr == 24'h9A5678, "R10 upper group shows latch", 32'(strobe_addr), 32'h9A5678);
    chk(n_psen == 1 && got_ext, "R4 fetch still strobes", n_psen, 1);

    // R10: data group in I/O role
    write_cfg(6'h37);
    io_data_latch = 8'h2D; io_data_oe = 1'b0;
    @(negedge clk);
    chk(data_pin_out == 8'h2D && !data_pin_oe, "R10 data group latch", {data_pin_oe, data_pin_out}, {1'b0, 8'h2D});
    write_cfg(6'h3F);

    // R9: priority fetch > read > write
    access(1'b1, 1'b1, 1'b1, 20'h00100, 8'h77, 8'h44);
    chk(n_psen == 1 && n_rd == 0 && n_wr == 0, "R9 fetch wins", {n_psen, n_rd}, {32'd1, 32'd0});
    access(1'b0, 1'b1, 1'b1, 20'h00200, 8'h77, 8'h55);
    chk(n_rd == 1 && n_wr == 0 && rdata == 8'h55, "R9 read beats write", {n_rd, n_wr}, {32'd1, 32'd0});

    // R9: request while busy is dropped
    @(negedge clk);
    fetch_req = 1'b1; fetch_addr = 20'h30000;
    @(negedge clk);
    fetch_req = 1'b0;
    rd_req = 1'b1; dm_addr = 20'h00300;
    @(negedge clk);
    rd_req = 1'b0;
    begin
      int rd_lows;
      rd_lows = 0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (!rd_n) rd_lows++;
      end
      chk(rd_lows == 0 && !busy, "R9 busy drops request", rd_lows, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule